// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block produces the next negative, zero, carry and overflow flags for a processor's status register from the outcome of one ALU operation. The ALU result, the raw adder carry-out and the two operand sign bits come in alongside the operation class (add, subtract, logical, move), the shifter's used indication and its last shifted-out bit, and a few control bits that say whether this operation is allowed to touch the flags at all. The status register's current flags are fed back in so that flags an operation does not produce are carried through untouched.

One registered stage sits between inputs and outputs. Each valid operation yields, one clock later, a flag nibble, a flag write enable for the status register, and a register writeback enable that is dropped for comparison operations. Flags are written by comparisons unconditionally, and by other operations only when flag setting is requested and the destination is not the program counter. The ALU and the shifter themselves are outside this block.

Top module: `alu_flag_gen`

## Requirements
- R1: When flags are written, flag bit 3 (negative) of `flags_o` equals the most significant bit of the result.
- R2: When flags are written, flag bit 2 (zero) is 1 exactly when every bit of the result is 0.
- R3: For op class 2'b00 (add), flag bit 1 (carry) equals the adder carry-out input.
- R4: For op class 2'b01 (subtract, computed as a + ~b + 1), flag bit 1 equals the adder carry-out, so it is 1 when no borrow occurs and 0 when one does.
- R5: For op class 2'b10 (logical) or 2'b11 (move), flag bit 1 takes the shifter's last shifted-out bit when the shifter is used and keeps the incoming previous carry (bit 1 of `prev_flags_i`) otherwise.
- R6: Flag bit 0 (overflow) is 1 for add when both operand signs agree and the result sign differs from them, and for subtract when the operand signs differ and the result sign differs from operand a; logical and move keep bit 0 of `prev_flags_i`.
- R7: Flags are written when `is_compare_i` is 1 regardless of `set_flags_i` and `dest_pc_i`, or when `set_flags_i` is 1 and `dest_pc_i` is 0; `reg_wb_o` is 1 for every valid operation that is not a comparison.
- R8: When flags are not written, `flag_we_o` is 0 and `flags_o` equals the `prev_flags_i` given with that operation.
- R9: Outputs appear one clock after the operation is presented, with `out_valid_o` marking them; reset and idle cycles give `out_valid_o`, `flag_we_o` and `reg_wb_o` of 0, and reset clears `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An operation is presented this cycle |
| op_class_i | input | 2 | 00 add, 01 subtract, 10 logical, 11 move |
| result_i | input | DATA_W | ALU result |
| adder_cout_i | input | 1 | Carry out of the adder's top bit |
| a_sign_i | input | 1 | Sign bit of operand a |
| b_sign_i | input | 1 | Sign bit of operand b (before inversion for subtract) |
| shift_used_i | input | 1 | The shifter took part in producing the operand |
| shift_cout_i | input | 1 | Last bit shifted out by the shifter |
| set_flags_i | input | 1 | Operation requests a flag update |
| is_compare_i | input | 1 | Operation is a comparison (flags only, no writeback) |
| dest_pc_i | input | 1 | Destination register is the program counter |
| prev_flags_i | input | 4 | Current status flags {N,Z,C,V} |
| out_valid_o | output | 1 | Registered outputs belong to a valid operation |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| flag_we_o | output | 1 | Write enable toward the status register flags |
| reg_wb_o | output | 1 | Register writeback enable |

## Verification
The assertions take for granted that the adder carry-out and the operand signs presented with an add or subtract are the ones the adder actually used to form `result_i`, so the overflow and carry properties only compare flags with those inputs rather than with any recomputed sum. The bench respects this by deriving every arithmetic stimulus from a pair of operands, forming the result and carry-out itself with a 33-bit sum of a and b or of a, the inverse of b and one, and taking the signs from the same operands. Logical and move stimulus supplies arbitrary results and shifter bits, since no relation between them is assumed.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_SUB   = 2'b01,
        OPC_LOGIC = 2'b10,
        OPC_MOVE  = 2'b11
    } op_class_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic is_arith(input op_class_e op);
        return (op == OPC_ADD) || (op == OPC_SUB);
    endfunction

    function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
        return (sa == sb) && (sr != sa);
    endfunction

    function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
        return (sa != sb) && (sr != sa);
    endfunction

endpackage

// File: rtl/flag_nz.sv
module flag_nz #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    output logic              neg,
    output logic              zero
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        neg  = result[MSB];
        zero = ~|result;
    end
endmodule

// File: rtl/flag_cv.sv
module flag_cv
    import alu_flag_pkg::*;
(
    input  op_class_e op,
    input  logic      adder_cout,
    input  logic      a_sign,
    input  logic      b_sign,
    input  logic      r_sign,
    input  logic      shift_used,
    input  logic      shift_cout,
    input  logic      prev_c,
    input  logic      prev_v,
    output logic      carry,
    output logic      ovf
);
    always_comb begin
        carry = prev_c;
        ovf   = prev_v;
        unique case (op)
            OPC_ADD: begin
                carry = adder_cout;
                ovf   = add_ovf(a_sign, b_sign, r_sign);
            end
            OPC_SUB: begin
                // adder forms a + ~b + 1: carry-out is the inverted borrow
                carry = adder_cout;
                ovf   = sub_ovf(a_sign, b_sign, r_sign);
            end
            default: begin
                if (shift_used) carry = shift_cout;
            end
        endcase
    end
endmodule

// File: rtl/flag_wctl.sv
module flag_wctl (
    input  logic valid,
    input  logic is_compare,
    input  logic set_flags,
    input  logic dest_pc,
    output logic flag_we,
    output logic reg_wb
);
    logic flag_req;

    always_comb begin
        flag_req = is_compare | (set_flags & ~dest_pc);
        flag_we  = valid & flag_req;
        reg_wb   = valid & ~is_compare;
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [1:0]        op_class_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              adder_cout_i,
    input  logic              a_sign_i,
    input  logic              b_sign_i,
    input  logic              shift_used_i,
    input  logic              shift_cout_i,
    input  logic              set_flags_i,
    input  logic              is_compare_i,
    input  logic              dest_pc_i,
    input  logic [3:0]        prev_flags_i,
    output logic              out_valid_o,
    output logic [3:0]        flags_o,
    output logic              flag_we_o,
    output logic              reg_wb_o
);
    localparam int MSB = DATA_W - 1;

    op_class_e op;
    flags_t    prev_f;
    flags_t    next_f;
    flags_t    sel_f;
    flags_t    flags_q;
    logic      we_c;
    logic      wb_c;
    logic      valid_q;
    logic      we_q;
    logic      wb_q;

    assign op     = op_class_e'(op_class_i);
    assign prev_f = flags_t'(prev_flags_i);

    flag_nz #(.DATA_W(DATA_W)) u_nz (
        .result (result_i),
        .neg    (next_f.n),
        .zero   (next_f.z)
    );

    flag_cv u_cv (
        .op         (op),
        .adder_cout (adder_cout_i),
        .a_sign     (a_sign_i),
        .b_sign     (b_sign_i),
        .r_sign     (result_i[MSB]),
        .shift_used (shift_used_i),
        .shift_cout (shift_cout_i),
        .prev_c     (prev_f.c),
        .prev_v     (prev_f.v),
        .carry      (next_f.c),
        .ovf        (next_f.v)
    );

    flag_wctl u_wctl (
        .valid      (valid_i),
        .is_compare (is_compare_i),
        .set_flags  (set_flags_i),
        .dest_pc    (dest_pc_i),
        .flag_we    (we_c),
        .reg_wb     (wb_c)
    );

    assign sel_f = we_c ? next_f : prev_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            we_q    <= 1'b0;
            wb_q    <= 1'b0;
            flags_q <= '0;
        end else begin
            valid_q <= valid_i;
            we_q    <= we_c;
            wb_q    <= wb_c;
            flags_q <= sel_f;
        end
    end

    assign out_valid_o = valid_q;
    assign flags_o     = flags_q;
    assign flag_we_o   = we_q;
    assign reg_wb_o    = wb_q;

    // ---------------- assertions ----------------
    logic wr_in;
    assign wr_in = valid_i && (is_compare_i || (set_flags_i && !dest_pc_i));

    p_neg_r1: assert property (@(posedge clk) disable iff (rst)
        wr_in |=> flags_o[3] == $past(result_i[MSB]));

    p_zero_r2: assert property (@(posedge clk) disable iff (rst)
        wr_in |=> flags_o[2] == ($past(result_i) == '0));

    p_add_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_in && op_class_i == 2'b00) |=> flags_o[1] == $past(adder_cout_i));

    p_sub_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_in && op_class_i == 2'b01) |=> flags_o[1] == $past(adder_cout_i));

    p_hold_carry_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_in && op_class_i[1] && !shift_used_i) |=> flags_o[1] == $past(prev_flags_i[1]));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_in && op_class_i[1]) |=> flags_o[0] == $past(prev_flags_i[0]));

    p_cmp_nowb_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && is_compare_i) |=> flag_we_o && !reg_wb_o);

    p_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !wr_in) |=> !flag_we_o && flags_o == $past(prev_flags_i));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !out_valid_o && !flag_we_o && !reg_wb_o);

    p_valid_r9: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> out_valid_o);

endmodule

// File: tb/alu_flag_gen_bench.sv
`timescale 1ns/1ps
module alu_flag_gen_bench;
    localparam int DW = 32;
    localparam int MAX_CYC = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_i = 1'b0;
    logic [1:0]    op_class_i = '0;
    logic [DW-1:0] result_i = '0;
    logic          adder_cout_i = 1'b0;
    logic          a_sign_i = 1'b0;
    logic          b_sign_i = 1'b0;
    logic          shift_used_i = 1'b0;
    logic          shift_cout_i = 1'b0;
    logic          set_flags_i = 1'b0;
    logic          is_compare_i = 1'b0;
    logic          dest_pc_i = 1'b0;
    logic [3:0]    prev_flags_i = '0;
    logic          out_valid_o;
    logic [3:0]    flags_o;
    logic          flag_we_o;
    logic          reg_wb_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [3:0] flags;
        logic       we;
        logic       wb;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    alu_flag_gen #(.DATA_W(DW)) u_alu_flag_gen (
        .clk, .rst, .valid_i, .op_class_i, .result_i, .adder_cout_i,
        .a_sign_i, .b_sign_i, .shift_used_i, .shift_cout_i, .set_flags_i,
        .is_compare_i, .dest_pc_i, .prev_flags_i, .out_valid_o, .flags_o,
        .flag_we_o, .reg_wb_o
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference from the requirements
    function automatic exp_t model(input logic [1:0] op, input logic [DW-1:0] res,
                                   input logic co, input logic sa, input logic sb,
                                   input logic su, input logic sc, input logic sf,
                                   input logic cmp, input logic dpc, input logic [3:0] prev,
                                   input string tag);
        exp_t e;
        logic wr;
        logic n, z, c, v;
        wr = cmp || (sf && !dpc);
        n = res[DW-1];
        z = (res == '0);
        c = prev[1];
        v = prev[0];
        if (op == 2'b00) begin
            c = co;
            v = (sa == sb) && (res[DW-1] != sa);
        end else if (op == 2'b01) begin
            c = co;
            v = (sa != sb) && (res[DW-1] != sa);
        end else if (su) begin
            c = sc;
        end
        e.flags = wr ? {n, z, c, v} : prev;
        e.we = wr;
        e.wb = !cmp;
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input logic [1:0] op, input logic [DW-1:0] res, input logic co,
                         input logic sa, input logic sb, input logic su, input logic sc,
                         input logic sf, input logic cmp, input logic dpc,
                         input logic [3:0] prev, input string tag);
        @(negedge clk);
        valid_i = 1'b1; op_class_i = op; result_i = res; adder_cout_i = co;
        a_sign_i = sa; b_sign_i = sb; shift_used_i = su; shift_cout_i = sc;
        set_flags_i = sf; is_compare_i = cmp; dest_pc_i = dpc; prev_flags_i = prev;
        q.push_back(model(op, res, co, sa, sb, su, sc, sf, cmp, dpc, prev, tag));
    endtask

    task automatic arith(input logic sub, input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic sf, input logic cmp, input logic dpc,
                         input logic [3:0] prev, input string tag);
        logic [DW:0] s;
        if (sub) s = {1'b0, a} + {1'b0, ~b} + 1;
        else     s = {1'b0, a} + {1'b0, b};
        drive({1'b0, sub}, s[DW-1:0], s[DW], a[DW-1], b[DW-1], 1'b0, 1'b0,
              sf, cmp, dpc, prev, tag);
    endtask

    task automatic idle;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (out_valid_o) begin
                if (q.size() == 0) begin
                    check("R9 unexpected out_valid", 32'(out_valid_o), 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.tag, " flags"}, 32'(flags_o), 32'(e.flags));
                    check({e.tag, " R7/R8 flag_we"}, 32'(flag_we_o), 32'(e.we));
                    check({e.tag, " R7 reg_wb"}, 32'(reg_wb_o), 32'(e.wb));
                end
            end else begin
                check("R9 idle flag_we", 32'(flag_we_o), 32'd0);
                check("R9 idle reg_wb", 32'(reg_wb_o), 32'd0);
            end
        end
    end

    initial begin
        #(20 * MAX_CYC);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R9 reset out_valid", 32'(out_valid_o), 32'd0);
        check("R9 reset flags", 32'(flags_o), 32'd0);
        check("R9 reset flag_we", 32'(flag_we_o), 32'd0);
        check("R9 reset reg_wb", 32'(reg_wb_o), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        idle();

        // add cases (R3, R6, R1, R2)
        arith(0, 32'hFFFF_FFFF, 32'h0000_0001, 1, 0, 0, 4'b0000, "R3 R2 add carry zero");
        arith(0, 32'h7FFF_FFFF, 32'h0000_0001, 1, 0, 0, 4'b0010, "R6 R1 add overflow");
        arith(0, 32'h8000_0000, 32'h8000_0000, 1, 0, 0, 4'b0000, "R6 R3 add neg overflow");
        arith(0, 32'h0000_0005, 32'h0000_0003, 1, 0, 0, 4'b1111, "R3 add plain");
        // subtract cases (R4, R6)
        arith(1, 32'h0000_0005, 32'h0000_0003, 1, 0, 0, 4'b0000, "R4 sub no borrow");
        arith(1, 32'h0000_0003, 32'h0000_0005, 1, 0, 0, 4'b0010, "R4 R1 sub borrow");
        arith(1, 32'h8000_0000, 32'h0000_0001, 1, 0, 0, 4'b0000, "R6 sub overflow");
        arith(1, 32'h1234_5678, 32'h1234_5678, 1, 0, 0, 4'b0001, "R4 R2 sub equal");
        // logical / move (R5, R6)
        drive(2'b10, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1, 0, 0, 4'b0001, "R5 R6 logic shift c=1");
        drive(2'b10, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1, 0, 0, 4'b0011, "R5 logic shift c=0");
        drive(2'b11, 32'h0000_0040, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1, 0, 0, 4'b0010, "R5 move hold carry 1");
        drive(2'b11, 32'h0000_0040, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1, 0, 0, 4'b0001, "R5 R6 move hold carry 0");
        // write control (R7, R8)
        arith(1, 32'h0000_0007, 32'h0000_0007, 0, 1, 0, 4'b1011, "R7 compare no set_flags");
        arith(0, 32'hFFFF_FFFF, 32'h0000_0001, 0, 1, 1, 4'b0000, "R7 compare dest_pc");
        drive(2'b10, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1, 1, 4'b1000, "R7 logic compare");
        arith(0, 32'h7FFF_FFFF, 32'h0000_0001, 1, 0, 1, 4'b0110, "R8 dest_pc no write");
        arith(1, 32'h0000_0000, 32'h0000_0001, 0, 0, 0, 4'b1001, "R8 no set_flags");
        drive(2'b11, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0, 0, 4'b0100, "R8 move no write");
        idle();
        idle();
        arith(0, 32'h0000_0001, 32'h0000_0001, 1, 0, 0, 4'b0000, "R9 after gap");
        idle();

        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            logic [1:0] op;
            logic [3:0] pv;
            logic sf, cmp, dpc;
            op  = 2'($urandom);
            pv  = 4'($urandom);
            sf  = 1'($urandom);
            cmp = ($urandom % 4) == 0;
            dpc = ($urandom % 4) == 0;
            if (op[1] == 1'b0)
                arith(op[0], $urandom, ($urandom % 8 == 0) ? 32'h0 : $urandom,
                      sf, cmp, dpc, pv, op[0] ? "R4 R6 R7 mix sub" : "R3 R6 R7 mix add");
            else
                drive(op, ($urandom % 8 == 0) ? 32'h0 : $urandom, 1'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      sf, cmp, dpc, pv, "R1 R2 R5 R8 mix logic");
            if ($urandom % 10 == 0) idle();
        end
        idle();
        repeat (4) @(negedge clk);
        #5;
        check("R9 queue drained", 32'(q.size()), 32'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule